// File: doc/BRIEF.md
# Infrared carrier modulator transmitter

This block drives a single infrared output. A carrier generator produces a square wave whose high and low times are each a programmable number of clocks. A mark/space modulator opens a gate for the mark time of each modulator cycle and closes it for the space time. The output carries the carrier only while the gate is open. A simple write port loads two carrier count sets, the mark and space counts, and a control word.

In FSK mode, the two carrier sets take turns, one modulator cycle each, with no software involvement. In baseband mode the carrier is a constant high level, so the output is the gate itself. The modulator can advance on every clock or once per carrier period. An extended-space control turns every following modulator cycle into a silent cycle. When the generator is disabled, a control bit drives the output directly.

Each modulator cycle ends with a one-clock pulse. A zero carrier count is reported on a sticky error flag instead of stalling the generator.

Top module: `ir_carrier_mod`

## Requirements
- R1: Write port map. Address 0 is the primary high count, 1 the primary low count, 2 the secondary high count, 3 the secondary low count, 4 the mark count and 5 the space count. Address 6 is the control word: bit 0 enable, bit 1 baseband, bit 2 FSK, bit 3 extended space, bit 4 output latch, bit 5 carrier-clocked modulator. After reset, ir_out, cycle_end and cfg_err are all 0.
- R2: While enable is 0, ir_out equals the output latch bit and cycle_end stays 0.
- R3: In the first clock after enable is written to 1, the carrier is in its high phase with the primary set, and the modulator is at the start of its mark phase. The carrier is then high for the active high count of clocks and low for the active low count, and repeats.
- R4: A modulator cycle lasts mark plus space ticks, mark first. ir_out follows the carrier during mark and is 0 during space.
- R5: cycle_end is 1 for exactly the last clock of each modulator cycle.
- R6: The mark and space counts are taken from the registers only at enable and at each cycle_end. A write during a cycle takes effect from the next cycle.
- R7: With baseband set, the carrier is constantly high, so ir_out equals the modulator gate.
- R8: With FSK set, the active carrier set swaps at every cycle_end, starting with the primary set. The carrier restarts in its high phase at each swap.
- R9: With the carrier-clocked bit set and baseband clear, the modulator advances once per completed carrier period instead of once per clock.
- R10: Extended space is sampled at each cycle_end. While it is set, every following modulator cycle keeps ir_out at 0 for its full length, and cycle_end still pulses.
- R11: If the active carrier high or low count is zero while enabled and not in baseband, the carrier is held low, so ir_out is 0. cfg_err is set one clock later and stays set while enabled. It clears one clock after enable returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DW | Write data, DW is the largest of MW, CW and 6 |
| ir_out | output | 1 | Infrared output level |
| cycle_end | output | 1 | One-clock pulse at the last clock of each modulator cycle |
| cfg_err | output | 1 | Sticky flag for a zero carrier count |

## Verification
The bench builds the block with CW=3 and MW=6, so the data word is exactly the six control bits wide. Small carrier and modulator counts make every cycle a few clocks long. Each scenario therefore covers several complete modulator cycles clock by clock, including the FSK swap, a mid-cycle mark rewrite, the extended-space transition and the carrier-clocked modulator. The zero-count path and the clearing of the error flag are reached with one write.

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod #(
  parameter int CW = 8,
  parameter int MW = 16,
  localparam int WMAX = (MW > CW) ? MW : CW,
  localparam int DW = (WMAX < 6) ? 6 : WMAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          ir_out,
  output logic          cycle_end,
  output logic          cfg_err
);

  logic [CW-1:0] pri_hi, pri_lo, sec_hi, sec_lo;
  logic [MW-1:0] mark_r, space_r;
  logic en, base, fsk, ext, latch, csel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_hi <= '0; pri_lo <= '0; sec_hi <= '0; sec_lo <= '0;
      mark_r <= '0; space_r <= '0;
      {csel, latch, ext, fsk, base, en} <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: pri_hi  <= wr_data[CW-1:0];
        3'd1: pri_lo  <= wr_data[CW-1:0];
        3'd2: sec_hi  <= wr_data[CW-1:0];
        3'd3: sec_lo  <= wr_data[CW-1:0];
        3'd4: mark_r  <= wr_data[MW-1:0];
        3'd5: space_r <= wr_data[MW-1:0];
        3'd6: {csel, latch, ext, fsk, base, en} <= wr_data[5:0];
        default: ;
      endcase
    end
  end

  logic          car_hi, car_sel;
  logic [CW-1:0] car_cnt;
  logic [MW:0]   pos;
  logic [MW-1:0] cur_mk, cur_sp;
  logic          ext_act;

  wire [CW-1:0] act_hi = car_sel ? sec_hi : pri_hi;
  wire [CW-1:0] act_lo = car_sel ? sec_lo : pri_lo;
  wire          bad    = (act_hi == '0) || (act_lo == '0);
  wire          run    = en && !base;
  wire [CW:0]   cnt_nx = (CW+1)'(car_cnt) + (CW+1)'(1);
  wire          hi_done = cnt_nx >= (CW+1)'(act_hi);
  wire          lo_done = cnt_nx >= (CW+1)'(act_lo);
  wire          per_tick = run && !bad && !car_hi && lo_done;
  wire          tick   = (csel && !base) ? per_tick : 1'b1;
  wire [MW:0]   total  = (MW+1)'(cur_mk) + (MW+1)'(cur_sp);
  wire          last   = ((MW+2)'(pos) + (MW+2)'(1)) >= (MW+2)'(total);
  wire          gate   = (pos < (MW+1)'(cur_mk)) && !ext_act;
  wire          car_out = base || (!bad && car_hi);

  assign cycle_end = en && tick && last;
  assign ir_out    = en ? (gate && car_out) : latch;

  always_ff @(posedge clk) begin
    if (!rst_n || !run || bad || (cycle_end && fsk)) begin
      car_hi  <= 1'b1;
      car_cnt <= '0;
    end else if (car_hi) begin
      car_hi  <= !hi_done;
      car_cnt <= hi_done ? '0 : cnt_nx[CW-1:0];
    end else begin
      car_hi  <= lo_done;
      car_cnt <= lo_done ? '0 : cnt_nx[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en)
      car_sel <= 1'b0;
    else if (cycle_end && fsk)
      car_sel <= !car_sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; cur_mk <= '0; cur_sp <= '0; ext_act <= 1'b0;
    end else if (!en || cycle_end) begin
      pos     <= '0;
      cur_mk  <= mark_r;
      cur_sp  <= space_r;
      ext_act <= en && ext;
    end else if (tick) begin
      pos <= pos + (MW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en)
      cfg_err <= 1'b0;
    else if (run && bad)
      cfg_err <= 1'b1;
  end

endmodule

module ir_carrier_mod_chk #(
  parameter int CW = 8,
  parameter int MW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          base,
  input logic          fsk,
  input logic          latch,
  input logic          bad,
  input logic          car_hi,
  input logic          car_sel,
  input logic [MW:0]   pos,
  input logic [MW-1:0] cur_mk,
  input logic          ext_act,
  input logic          ir_out,
  input logic          cycle_end,
  input logic          cfg_err
);
  assert_latch_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (ir_out == latch) && !cycle_end);
  assert_start_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en)) |-> car_hi && !car_sel && pos == '0);
  assert_gate_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ir_out) |-> (pos < (MW+1)'(cur_mk)) && !ext_act);
  assert_cycle_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> pos == '0);
  assert_fsk_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && fsk && en) |=> car_sel != $past(car_sel));
  assert_zero_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !base && bad) |-> !ir_out);
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cfg_err) |=> cfg_err);
endmodule

bind ir_carrier_mod ir_carrier_mod_chk #(.CW(CW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .base(base), .fsk(fsk), .latch(latch),
  .bad(bad), .car_hi(car_hi), .car_sel(car_sel), .pos(pos), .cur_mk(cur_mk),
  .ext_act(ext_act), .ir_out(ir_out), .cycle_end(cycle_end), .cfg_err(cfg_err)
);

// File: tb/test_ir_carrier_mod.sv
module test_ir_carrier_mod;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  wire        ir_out, cycle_end, cfg_err;
  int checks = 0;
  int errors = 0;

  ir_carrier_mod #(.CW(3), .MW(6)) i_ir_carrier_mod (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ir_out(ir_out), .cycle_end(cycle_end), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[5:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stop_gen();
    wr(6, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "ir_out", int'(ir_out), 0);
    chk("R1", "cycle_end", int'(cycle_end), 0);
    chk("R1", "cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_latch();
    wr(6, 16);
    chk("R2", "ir_out latch=1", int'(ir_out), 1);
    @(negedge clk);
    chk("R2", "ir_out held", int'(ir_out), 1);
    chk("R2", "cycle_end idle", int'(cycle_end), 0);
    wr(6, 0);
    chk("R2", "ir_out latch=0", int'(ir_out), 0);
  endtask

  task automatic t_normal();
    wr(0, 2); wr(1, 3); wr(4, 10); wr(5, 5); wr(6, 1);
    for (int k = 0; k < 24; k++) begin
      int j, len, mk;
      string req;
      if (k > 0) @(negedge clk);
      if (k == 3) begin wr_en = 1'b1; wr_addr = 3'd4; wr_data = 6'd4; end
      if (k == 4) wr_en = 1'b0;
      j   = (k < 15) ? k : k - 15;
      mk  = (k < 15) ? 10 : 4;
      len = (k < 15) ? 15 : 9;
      req = (k < 10) ? "R3" : (k < 15) ? "R4" : "R6";
      chk(req, "ir_out", int'(ir_out), (j < mk) ? int'((k % 5) < 2) : 0);
      chk("R5", "cycle_end", int'(cycle_end), int'(j == len - 1));
    end
    stop_gen();
  endtask

  task automatic t_baseband();
    wr(4, 3); wr(5, 2); wr(6, 3);
    for (int k = 0; k < 10; k++) begin
      if (k > 0) @(negedge clk);
      chk("R7", "ir_out", int'(ir_out), int'((k % 5) < 3));
      chk("R7", "cycle_end", int'(cycle_end), int'((k % 5) == 4));
    end
    stop_gen();
  endtask

  task automatic t_fsk();
    wr(0, 1); wr(1, 1); wr(2, 2); wr(3, 2); wr(4, 6); wr(5, 2); wr(6, 5);
    for (int k = 0; k < 24; k++) begin
      int j, c, exp;
      if (k > 0) @(negedge clk);
      j = k % 8;
      c = k / 8;
      exp = (j >= 6) ? 0 : ((c % 2) == 1) ? int'((j % 4) < 2) : int'((j % 2) == 0);
      chk("R8", "ir_out", int'(ir_out), exp);
      chk("R8", "cycle_end", int'(cycle_end), int'(j == 7));
    end
    stop_gen();
  endtask

  task automatic t_carrier_clock();
    wr(0, 1); wr(1, 1); wr(4, 2); wr(5, 1); wr(6, 33);
    for (int k = 0; k < 12; k++) begin
      int j;
      if (k > 0) @(negedge clk);
      j = k % 6;
      chk("R9", "ir_out", int'(ir_out), (j < 4) ? int'((j % 2) == 0) : 0);
      chk("R9", "cycle_end", int'(cycle_end), int'(j == 5));
    end
    stop_gen();
  endtask

  task automatic t_ext_space();
    wr(0, 2); wr(1, 3); wr(4, 10); wr(5, 5); wr(6, 9);
    for (int k = 0; k < 30; k++) begin
      int j;
      if (k > 0) @(negedge clk);
      j = k % 15;
      chk("R10", "ir_out", int'(ir_out), (k < 10) ? int'((k % 5) < 2) : 0);
      chk("R10", "cycle_end", int'(cycle_end), int'(j == 14));
    end
    stop_gen();
  endtask

  task automatic t_zero_count();
    wr(0, 2); wr(1, 0); wr(6, 1);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) @(negedge clk);
      chk("R11", "ir_out", int'(ir_out), 0);
      if (k >= 1) chk("R11", "cfg_err set", int'(cfg_err), 1);
    end
    stop_gen();
    chk("R11", "cfg_err cleared", int'(cfg_err), 0);
    wr(1, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_normal();
    t_baseband();
    t_fsk();
    t_carrier_clock();
    t_ext_space();
    t_zero_count();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule